// File: doc/BRIEF.md
# Memory Controller Activity Counter Bank

This block is a bank of four activity counters for a memory controller, reached through a simple 32-bit register port with separate read and write strobes. Slot 0 counts only clock cycles and acts as the master time base. Slots 1 to 3 each count one event. An 8-bit code in the slot's control word picks that event from a vector of single-cycle event strobes.

Each slot has a control word and a read-only count word. The control word holds an enable, a clear bit, a sticky overflow flag, an 8-bit seed and the event code. Turning a slot on seeds bits 23:16 of its count from the seed field. A large seed shortens the time to the cycle counter's overflow.

An event slot that reaches its top value stops there and sets its flag. When the cycle slot reaches its top value, every slot freezes and the level interrupt rises. Software then reads the slots, clears the cycle slot and resumes.

Top module: `mcpb_bank`

## Requirements
- R1: After reset, every count reads 0 and `irq` is low. Control word 0 reads 0x00000000, and control words 1 to 3 read 0x00000002 (clear bit at rest high).
- R2: Control word n sits at byte address 4*n and count n at 0x20+4*n. A read returns the addressed word on `rdata` one clock after `rd_en`, and any other address reads 0. The control word fields are: bit 0 sticky overflow (written bits are ignored), bit 1 clear, bit 2 enable, bits 23:16 seed, bits 31:24 event code. For slot 0 the event code always reads 0.
- R3: While slot 0 is enabled and its flag is low, its count rises by one on every clock.
- R4: Slot n (1..3) rises by one on each clock where `evt_strobe[code]` is high, the slot is enabled, its own flag is low, and slot 0 is enabled with its flag low. A code at or above NUM_EVT never matches.
- R5: A write that changes enable from 0 to 1 loads the count with the seed placed at bits PRE_LSB+7:PRE_LSB (23:16 by default) and clears the flag.
- R6: Slot 0 clears (count and flag to 0) only on a write whose clear bit is 1 while the stored clear bit is 0. A write of clear=1 over a stored 1 changes nothing.
- R7: Slot n (1..3) clears on any write with clear bit 0. Its clear bit then returns to 1 on the next clock by itself.
- R8: An event slot at its all-ones value that would step again holds that value and sets its flag, and no interrupt follows.
- R9: When slot 0 would step past all ones, it holds, sets its flag and raises `irq`, and every event slot stops counting.
- R10: While slot 0 is disabled, no event slot counts.
- R11: `irq` equals slot 0's flag. It stays high through writes that do not clear slot 0 and drops on the clock of the clear.
- R12: Writes to count addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe, one word per clock |
| rd_en | input | 1 | Read strobe; `rdata` updates on the next clock |
| addr | input | 8 | Byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, held between reads |
| evt_strobe | input | NUM_EVT | Event strobes, one per event code |
| irq | output | 1 | Level interrupt on cycle-slot overflow |

## Verification
The assertions assume that the register port issues at most one write per clock and that strobes are sampled synchronously. Their freeze checks hold only in cycles with no write, because a write may legally seed or clear an event slot while the bank is stopped. The stimulus changes strobes, addresses and data only at falling edges and issues writes one at a time. It restarts the cycle slot before each timed measurement, so an earlier overflow of the short bench-width cycle slot never spills into a later case.

// File: rtl/mcpb_pkg.sv
package mcpb_pkg;

  // control word bit positions (the bus-visible layout)
  localparam int BIT_OVF  = 0;
  localparam int BIT_CLR  = 1;
  localparam int BIT_EN   = 2;
  localparam int PRE_LO   = 16;
  localparam int SEL_LO   = 24;

  // address pages (addr[7:5])
  localparam logic [2:0] PAGE_CTRL = 3'd0;
  localparam logic [2:0] PAGE_CNT  = 3'd1;

  typedef struct packed {
    logic [7:0]  sel;
    logic [7:0]  pre;
    logic [12:0] rsv;
    logic        en;
    logic        clr;
    logic        ovf;
  } ctrl_word_t;

  // builds the read image of a control word, reserved bits zero
  function automatic logic [31:0] pack_ctrl(logic [7:0] sel, logic [7:0] pre,
                                            logic en, logic clr, logic ovf);
    ctrl_word_t w;
    w.sel = sel;
    w.pre = pre;
    w.rsv = '0;
    w.en  = en;
    w.clr = clr;
    w.ovf = ovf;
    return w;
  endfunction

  // clear request rule: cycle slot clears on a 0->1 clear bit, event slots on a written 0
  function automatic logic clear_request(logic is_cyc, logic old_clr, logic new_clr);
    return is_cyc ? (new_clr & ~old_clr) : ~new_clr;
  endfunction

endpackage

// File: rtl/mcpb_counter.sv
module mcpb_counter #(
  parameter int CNT_W   = 32,
  parameter int PRE_LSB = 16,
  parameter int NUM_EVT = 64,
  parameter bit IS_CYC  = 1'b0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr,
  input  logic [31:0]        wdata,
  input  logic [NUM_EVT-1:0] evt,
  input  logic               bank_run,
  output logic [31:0]        ctrl_rd,
  output logic [CNT_W-1:0]   cnt_q
);
  import mcpb_pkg::*;

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic       en_q, clr_q, ovf_q;
  logic [7:0] pre_q, sel_q;

  // named internal events
  logic hit, gate_ok, load_ev, clear_ev, inc_ev, at_max;
  logic w_en, w_clr;
  logic [7:0] w_pre, w_sel;
  logic unused_wbits;

  assign w_en  = wdata[BIT_EN];
  assign w_clr = wdata[BIT_CLR];
  assign w_pre = wdata[PRE_LO +: 8];
  assign w_sel = wdata[SEL_LO +: 8];
  assign unused_wbits = ^{wdata[15:3], wdata[BIT_OVF]};

  function automatic logic [CNT_W-1:0] seed_value(logic [7:0] pre);
    return CNT_W'(pre) << PRE_LSB;
  endfunction

  function automatic logic [CNT_W-1:0] step(logic [CNT_W-1:0] c);
    return c + CNT_W'(1);
  endfunction

  always_comb begin
    hit = 1'b0;
    if (IS_CYC) begin
      hit = 1'b1;
    end else begin
      for (int i = 0; i < NUM_EVT; i++) begin
        if (sel_q == 8'(i)) hit = hit | evt[i];
      end
    end
  end

  assign gate_ok  = IS_CYC ? 1'b1 : bank_run;
  assign load_ev  = wr & w_en & ~en_q;
  assign clear_ev = wr & clear_request(IS_CYC, clr_q, w_clr);
  assign inc_ev   = en_q & ~ovf_q & gate_ok & hit;
  assign at_max   = (cnt_q == CNT_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      clr_q <= ~IS_CYC;
      ovf_q <= 1'b0;
      pre_q <= '0;
      sel_q <= '0;
      cnt_q <= '0;
    end else begin
      if (wr) begin
        en_q  <= w_en;
        clr_q <= w_clr;
        pre_q <= w_pre;
        sel_q <= IS_CYC ? 8'h00 : w_sel;
      end else if (!IS_CYC) begin
        clr_q <= 1'b1;
      end

      if (load_ev) begin
        cnt_q <= seed_value(w_pre);
        ovf_q <= 1'b0;
      end else if (clear_ev) begin
        cnt_q <= '0;
        ovf_q <= 1'b0;
      end else if (inc_ev) begin
        if (at_max) ovf_q <= 1'b1;
        else        cnt_q <= step(cnt_q);
      end
    end
  end

  assign ctrl_rd = pack_ctrl(sel_q, pre_q, en_q, clr_q, ovf_q);

  // R8: the flag stays set until a seed load or a clear
  a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q && !load_ev && !clear_ev |=> ovf_q);

  // R8 / R9: a flagged slot holds its value
  a_r8_hold_at_top: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q && !load_ev && !clear_ev |=> $stable(cnt_q));

  generate
    if (!IS_CYC) begin : g_evt_chk
      // R7: an event slot's clear bit comes back high by itself
      a_r7_clr_returns: assert property (@(posedge clk) disable iff (!rst_n)
        !wr && !clr_q |=> clr_q);
      // R10: no counting while the bank is halted
      a_r10_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !bank_run && !wr |=> $stable(cnt_q));
    end
  endgenerate

endmodule

// File: rtl/mcpb_decode.sv
module mcpb_decode #(
  parameter int NUM_CNT = 4,
  parameter int CNT_W   = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic                          rd_en,
  input  logic [7:0]                    addr,
  input  logic [NUM_CNT-1:0][31:0]      ctrl_all,
  input  logic [NUM_CNT-1:0][CNT_W-1:0] cnt_all,
  output logic [NUM_CNT-1:0]            ctrl_wr,
  output logic [31:0]                   rdata
);
  import mcpb_pkg::*;

  logic [2:0]  idx;
  logic        aligned, idx_ok, in_ctrl, in_cnt;
  logic [31:0] rd_mux;

  assign idx     = addr[4:2];
  assign aligned = (addr[1:0] == 2'b00);
  assign idx_ok  = (32'(idx) < NUM_CNT);
  assign in_ctrl = (addr[7:5] == PAGE_CTRL) && aligned && idx_ok;
  assign in_cnt  = (addr[7:5] == PAGE_CNT) && aligned && idx_ok;

  generate
    for (genvar g = 0; g < NUM_CNT; g++) begin : g_wsel
      assign ctrl_wr[g] = wr_en & in_ctrl & (idx == 3'(g));
    end
  endgenerate

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NUM_CNT; i++) begin
      if (in_ctrl && idx == 3'(i)) rd_mux = ctrl_all[i];
      if (in_cnt  && idx == 3'(i)) rd_mux = 32'(cnt_all[i]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end

  // R2: at most one control word written per access
  a_r2_one_target: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ctrl_wr));

  // R12: a write to a count address reaches no control word
  a_r12_cnt_read_only: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && in_cnt |-> ctrl_wr == '0);

endmodule

// File: rtl/mcpb_bank.sv
module mcpb_bank #(
  parameter int NUM_CNT = 4,
  parameter int CNT_W   = 32,
  parameter int PRE_LSB = 16,
  parameter int NUM_EVT = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [7:0]         addr,
  input  logic [31:0]        wdata,
  output logic [31:0]        rdata,
  input  logic [NUM_EVT-1:0] evt_strobe,
  output logic               irq
);
  import mcpb_pkg::*;

  logic [NUM_CNT-1:0][31:0]      ctrl_all;
  logic [NUM_CNT-1:0][CNT_W-1:0] cnt_all;
  logic [NUM_CNT-1:0]            ctrl_wr;
  logic                          bank_run;

  // the cycle slot gates the whole bank
  assign bank_run = ctrl_all[0][BIT_EN] & ~ctrl_all[0][BIT_OVF];
  assign irq      = ctrl_all[0][BIT_OVF];

  mcpb_decode #(.NUM_CNT(NUM_CNT), .CNT_W(CNT_W)) u_dec (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .addr     (addr),
    .ctrl_all (ctrl_all),
    .cnt_all  (cnt_all),
    .ctrl_wr  (ctrl_wr),
    .rdata    (rdata)
  );

  generate
    for (genvar g = 0; g < NUM_CNT; g++) begin : g_slot
      mcpb_counter #(
        .CNT_W   (CNT_W),
        .PRE_LSB (PRE_LSB),
        .NUM_EVT (NUM_EVT),
        .IS_CYC  (g == 0)
      ) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (ctrl_wr[g]),
        .wdata    (wdata),
        .evt      (evt_strobe),
        .bank_run (bank_run),
        .ctrl_rd  (ctrl_all[g]),
        .cnt_q    (cnt_all[g])
      );
    end
  endgenerate

  // R9: with the interrupt up and no write, every event slot is frozen
  a_r9_bank_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !wr_en |=> $stable(cnt_all[NUM_CNT-1:1]));

  // R10: cycle slot disabled and no write -> event slots frozen
  a_r10_master_off: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_all[0][BIT_EN] && !wr_en |=> $stable(cnt_all[NUM_CNT-1:1]));

  // R11: the interrupt only rises through the cycle slot stepping at its top
  a_r11_irq_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(cnt_all[0]) == '1);

endmodule

// File: tb/sim_mcpb_bank.sv
`timescale 1ns/1ps
module sim_mcpb_bank;
  localparam int CW = 12;
  localparam int PL = 4;
  localparam int NE = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic          rd_en = 1'b0;
  logic [7:0]    addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic [NE-1:0] evt = '0;
  logic          irq;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  mcpb_bank #(.NUM_CNT(4), .CNT_W(CW), .PRE_LSB(PL), .NUM_EVT(NE)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .evt_strobe(evt), .irq(irq)
  );

  // event code, strobe pattern, cycles held, expected count of slot 1
  typedef struct packed {
    logic [7:0]  sel;
    logic [7:0]  pat;
    logic [7:0]  n;
    logic [31:0] exp;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{8'd3,  8'h08, 8'd10, 32'd10},
    '{8'd3,  8'hF7, 8'd10, 32'd0},
    '{8'd7,  8'hFF, 8'd25, 32'd25},
    '{8'd0,  8'h01, 8'd5,  32'd5},
    '{8'h20, 8'hFF, 8'd12, 32'd0},
    '{8'd5,  8'h20, 8'd1,  32'd1}
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic put(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic get(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(posedge clk);
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic run_cyc(logic [7:0] pre);
    put(8'h00, 32'h0);
    put(8'h00, {8'h00, pre, 16'h0006});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, a0, b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    chk("R1 irq", {31'b0, irq}, 32'h0);
    get(8'h00, v); chk("R1 ctrl0", v, 32'h0);
    get(8'h04, v); chk("R1 ctrl1", v, 32'h2);
    get(8'h20, v); chk("R1 count0", v, 32'h0);

    // R2 layout, R5 seed load
    put(8'h04, 32'h37AB0006);
    get(8'h04, v); chk("R2 ctrl1 readback", v, 32'h37AB0006);
    get(8'h24, v); chk("R5 seed in count1", v, 32'h00000AB0);
    put(8'h00, 32'h55F00007);
    get(8'h00, v); chk("R2 ctrl0 code and flag", v, 32'h00F00006);
    get(8'h40, v); chk("R2 unmapped", v, 32'h0);
    put(8'h00, 32'h0);

    // R3 cycle counting
    run_cyc(8'h00);
    repeat (7) @(posedge clk);
    get(8'h20, v); chk("R3 cycle count", v, 32'd7);

    // R4 event selection, table walk
    for (int i = 0; i < 6; i++) begin
      put(8'h04, 32'h0);
      put(8'h04, {VEC[i].sel, 8'h00, 16'h0006});
      run_cyc(8'h00);
      evt = VEC[i].pat;
      repeat (int'(VEC[i].n)) @(posedge clk);
      @(negedge clk) evt = '0;
      get(8'h24, v); chk($sformatf("R4 vector %0d", i), v, VEC[i].exp);
    end

    // R8 event slot saturates without interrupt
    run_cyc(8'h00);
    put(8'h08, 32'h0);
    put(8'h08, 32'h01FF0006);
    evt = 8'h02;
    repeat (40) @(posedge clk);
    @(negedge clk) evt = '0;
    get(8'h28, v); chk("R8 count2 held", v, 32'h00000FFF);
    get(8'h08, v); chk("R8 flag2", v, 32'h01FF0007);
    chk("R8 no irq", {31'b0, irq}, 32'h0);

    // R7 event slot clear on written zero
    put(8'h08, 32'h01FF0004);
    get(8'h28, v); chk("R7 count2 cleared", v, 32'h0);
    get(8'h08, v); chk("R7 clear bit back", v, 32'h01FF0006);

    // R9 cycle overflow halts bank
    put(8'h0C, 32'h0);
    put(8'h0C, 32'h02000006);
    evt = 8'h04;
    run_cyc(8'hF0);
    repeat (300) @(posedge clk);
    chk("R9 irq high", {31'b0, irq}, 32'h1);
    get(8'h20, v); chk("R9 count0 held", v, 32'h00000FFF);
    get(8'h00, v); chk("R9 flag0", v, 32'h00F00007);
    get(8'h2C, a0);
    repeat (20) @(posedge clk);
    get(8'h2C, b0); chk("R9 count3 frozen", b0, a0);

    // R6 / R11 cycle slot clear protocol
    put(8'h00, 32'h00F00006);
    chk("R6 no clear over stored one", {31'b0, irq}, 32'h1);
    get(8'h20, v); chk("R6 count0 unchanged", v, 32'h00000FFF);
    put(8'h00, 32'h00F00004);
    chk("R11 irq held on clear low", {31'b0, irq}, 32'h1);
    put(8'h00, 32'h00F00006);
    chk("R11 irq dropped", {31'b0, irq}, 32'h0);
    get(8'h00, v); chk("R6 flag0 cleared", v, 32'h00F00006);

    // R10 disabling cycle slot stops event slots
    put(8'h00, 32'h0);
    get(8'h2C, a0);
    repeat (10) @(posedge clk);
    get(8'h2C, b0); chk("R10 count3 frozen", b0, a0);
    chk("R10 count3 had counted", {31'b0, (a0 != 0)}, 32'h1);
    evt = '0;

    // R12 count words are read-only
    put(8'h2C, 32'h00000123);
    get(8'h2C, v); chk("R12 count3 unchanged", v, a0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule